// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes a three-wire stereo audio stream (bit clock, frame clock and serial data) and turns it into parallel left and right samples. It decodes five framings: right-justified with a fixed word length, I2S, left-justified, a pulse-framed DSP mode and a packed 32-bit-clock-per-frame variant. Serial words are two's complement and arrive MSB first. The left word always comes before the right word in a frame.

All three serial inputs pass through a two-flop synchronizer into the system clock domain. The bit clock is then edge-detected there, so the system clock must run several times faster than the bit clock. Every decoded word is left-aligned into a 24-bit field, which keeps the sign in the top bit. When a right word completes, both samples of the frame are presented together with a one-cycle strobe. The format, word length and packed selections are static configuration and may only change while the block is held in reset.

Top module: `audio_rx_top`

## Requirements
- R1: While reset is asserted, and after it is released, `left_o`, `right_o` and `valid_o` are all zero until the first completed frame.
- R2: `fmt_i` selects the framing: 2'b00 right-justified, 2'b01 I2S, 2'b10 left-justified, 2'b11 DSP. In right- and left-justified modes a high frame clock marks the left half. In I2S a low frame clock marks the left half.
- R3: In left-justified mode the MSB is the bit sampled on the first rising bit-clock edge at which the new frame-clock level is seen (position 0 of the half).
- R4: In I2S mode the MSB is at position 1, one bit period after the frame-clock change. The bit at position 0 is ignored.
- R5: In right-justified mode `len_i` 2'b00, 2'b01 and 2'b10 select 24-, 20- and 16-bit words. Capture starts at position 8, 12 or 16 of the half and takes exactly that many bits, however long the half is. Bits before the start position and after the word are ignored.
- R6: In DSP mode bits are sampled on the falling bit-clock edge. A high frame-clock sample is a sync pulse and carries no data. The low-level bits that follow a pulse form one word. The first pulse after reset starts a left word, and the channels then alternate on each pulse.
- R7: With `packed_i` high in right-justified mode, capture starts at position 0 and fills the half, so 16-bit halves at 32 bit clocks per frame decode correctly.
- R8: In every mode at most 24 bits are kept per half. Later bits in the same half are dropped with no other effect.
- R9: A word of fewer than 24 bits appears left-aligned, with its MSB in bit 23 and zeros in the unused low bits.
- R10: `valid_o` pulses for exactly one system clock when a right half ends (at the next frame-clock change, or at the next DSP pulse). `left_o` and `right_o` change only in that cycle and carry the preceding left word and that right word.
- R11: A half that was already in progress when reset was released is discarded. No `valid_o` appears until a complete left half and a complete right half have both been received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Framing select (R2 encoding) |
| len_i | input | 2 | Right-justified word length select (R5 encoding) |
| packed_i | input | 1 | Packed framing enable for right-justified mode |
| sck_i | input | 1 | Serial bit clock, asynchronous |
| ws_i | input | 1 | Frame (left/right) clock, asynchronous |
| sd_i | input | 1 | Serial data, asynchronous |
| left_o | output | 24 | Left sample, left-aligned |
| right_o | output | 24 | Right sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
Two things can happen on the same sample strobe: a half is finalized and the next half's first bit is captured. This occurs whenever the MSB sits exactly on the frame-clock change, which is the case in left-justified mode and in packed right-justified mode. The bench provokes it by sending back-to-back frames with random words and no idle bits in those modes. The scoreboard then compares both neighbouring words of every pair. A lost or duplicated MSB, or a word that absorbs the first bit of its successor, shows up as a mismatch against the independently computed expected values.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_I2S = 2'b01,
    FMT_LJ  = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;
endpackage

// File: rtl/audio_rx_sync.sv
module audio_rx_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/audio_rx_edge.sv
module audio_rx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic fall_sel_i,
  output logic smp_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  // rising edge by default, falling edge when selected
  assign smp_o = fall_sel_i ? (sck_q & ~sck_i) : (sck_i & ~sck_q);
endmodule

// File: rtl/audio_rx_framer.sv
module audio_rx_framer
  import audio_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned RJ_SLOT  = 32,
  parameter int unsigned POS_W    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  fmt_e                fmt_i,
  input  logic [1:0]          len_i,
  input  logic                packed_i,
  input  logic                smp_i,
  input  logic                ws_i,
  input  logic                sd_i,
  output logic                done_o,
  output logic                done_left_o,
  output logic [SAMPLE_W-1:0] done_word_o
);
  localparam int unsigned NB_W  = $clog2(SAMPLE_W + 1);
  localparam int unsigned LEN_B = SAMPLE_W - 4;
  localparam int unsigned LEN_C = SAMPLE_W - 8;

  logic                ws_last_q, armed_q, cur_left_q;
  logic [POS_W-1:0]    cnt_q, pos_now, start_pos;
  logic [NB_W-1:0]     nbits_q, nbits_base, limit, rj_len;
  logic [SAMPLE_W-1:0] word_q, word_base;
  logic                is_dsp, boundary, take;

  always_comb begin
    case (len_i)
      2'b01:   rj_len = NB_W'(LEN_B);
      2'b10:   rj_len = NB_W'(LEN_C);
      default: rj_len = NB_W'(SAMPLE_W);
    endcase
  end

  always_comb begin
    start_pos = '0;
    limit     = NB_W'(SAMPLE_W);
    case (fmt_i)
      FMT_I2S: start_pos = POS_W'(1);
      FMT_RJ: begin
        if (!packed_i) begin
          start_pos = POS_W'(RJ_SLOT) - POS_W'(rj_len);
          limit     = rj_len;
        end
      end
      default: ;
    endcase
  end

  assign is_dsp     = (fmt_i == FMT_DSP);
  // DSP: a half starts on a rising pulse; otherwise on any level change
  assign boundary   = smp_i & (is_dsp ? (ws_i & ~ws_last_q) : (ws_i ^ ws_last_q));
  assign pos_now    = boundary ? '0 : ((&cnt_q) ? cnt_q : cnt_q + 1'b1);
  assign nbits_base = boundary ? '0 : nbits_q;
  assign word_base  = boundary ? '0 : word_q;
  assign take       = smp_i & (pos_now >= start_pos) & (nbits_base < limit)
                    & ~(is_dsp & ws_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_last_q  <= 1'b0;
      armed_q    <= 1'b0;
      cur_left_q <= 1'b0;
      cnt_q      <= '0;
      nbits_q    <= '0;
      word_q     <= '0;
    end else if (smp_i) begin
      ws_last_q <= ws_i;
      cnt_q     <= pos_now;
      nbits_q   <= nbits_base + NB_W'(take);
      word_q    <= take ? {word_base[SAMPLE_W-2:0], sd_i} : word_base;
      if (boundary) begin
        armed_q    <= 1'b1;
        cur_left_q <= is_dsp ? (~armed_q | ~cur_left_q)
                             : ((fmt_i == FMT_I2S) ? ~ws_i : ws_i);
      end
    end
  end

  assign done_o      = boundary & armed_q;
  assign done_left_o = cur_left_q;
  assign done_word_o = word_q << (NB_W'(SAMPLE_W) - nbits_q);
endmodule

// File: rtl/audio_rx_pair.sv
module audio_rx_pair #(
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                done_i,
  input  logic                done_left_i,
  input  logic [SAMPLE_W-1:0] done_word_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  logic [SAMPLE_W-1:0] left_hold_q;
  logic                left_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_hold_q <= '0;
      left_ok_q   <= 1'b0;
      left_o      <= '0;
      right_o     <= '0;
      valid_o     <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (done_i && done_left_i) begin
        left_hold_q <= done_word_i;
        left_ok_q   <= 1'b1;
      end else if (done_i && left_ok_q) begin
        left_o    <= left_hold_q;
        right_o   <= done_word_i;
        valid_o   <= 1'b1;
        left_ok_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_rx_top.sv
module audio_rx_top
  import audio_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_W    = 24,
  parameter int unsigned RJ_SLOT     = 32,
  parameter int unsigned POS_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          fmt_i,
  input  logic [1:0]          len_i,
  input  logic                packed_i,
  input  logic                sck_i,
  input  logic                ws_i,
  input  logic                sd_i,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  localparam int unsigned N_SER = 3;

  logic [N_SER-1:0]    ser_s;
  logic                smp_w, done_w, done_left_w;
  logic [SAMPLE_W-1:0] done_word_w;
  fmt_e                fmt_w;

  assign fmt_w = fmt_e'(fmt_i);

  audio_rx_sync #(.WIDTH(N_SER), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, ws_i, sd_i}),
    .q_o   (ser_s)
  );

  audio_rx_edge i_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_i     (ser_s[2]),
    .fall_sel_i(fmt_w == FMT_DSP),
    .smp_o     (smp_w)
  );

  audio_rx_framer #(.SAMPLE_W(SAMPLE_W), .RJ_SLOT(RJ_SLOT), .POS_W(POS_W)) i_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fmt_i      (fmt_w),
    .len_i      (len_i),
    .packed_i   (packed_i),
    .smp_i      (smp_w),
    .ws_i       (ser_s[1]),
    .sd_i       (ser_s[0]),
    .done_o     (done_w),
    .done_left_o(done_left_w),
    .done_word_o(done_word_w)
  );

  audio_rx_pair #(.SAMPLE_W(SAMPLE_W)) i_pair (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .done_i     (done_w),
    .done_left_i(done_left_w),
    .done_word_i(done_word_w),
    .left_o     (left_o),
    .right_o    (right_o),
    .valid_o    (valid_o)
  );
endmodule

// File: rtl/audio_rx_chk.sv
module audio_rx_chk #(
  parameter int unsigned W = 24
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   fmt_i,
  input logic [1:0]   len_i,
  input logic         packed_i,
  input logic [W-1:0] left_o,
  input logic [W-1:0] right_o,
  input logic         valid_o,
  input logic         done_i,
  input logic         done_left_i
);
  logic [1:0] n_done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   n_done_q <= '0;
    else if (done_i && !n_done_q[1]) n_done_q <= n_done_q + 2'd1;
  end

  p_valid_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_hold_between_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($stable(left_o) && $stable(right_o)) |-> valid_o);

  p_after_right_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(done_i && !done_left_i));

  p_two_halves_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> n_done_q[1]);

  p_rj16_low_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && fmt_i == 2'b00 && len_i == 2'b10 && !packed_i)
      |-> (left_o[W-17:0] == '0 && right_o[W-17:0] == '0));
endmodule

bind audio_rx_top audio_rx_chk #(.W(SAMPLE_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fmt_i      (fmt_i),
  .len_i      (len_i),
  .packed_i   (packed_i),
  .left_o     (left_o),
  .right_o    (right_o),
  .valid_o    (valid_o),
  .done_i     (done_w),
  .done_left_i(done_left_w)
);

// File: tb/test_audio_rx_top.sv
module test_audio_rx_top;
  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt = 2'b00, len = 2'b00;
  logic        pk = 1'b0, sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [23:0] left, right;
  logic        valid;

  int checks = 0, fails = 0;
  logic [47:0] exp_q [$];
  string       tag_q [$];
  logic [47:0] e;
  string       t;

  always #4 clk = ~clk;

  audio_rx_top i_audio_rx_top (
    .clk_i(clk), .rst_ni(rst_n), .fmt_i(fmt), .len_i(len), .packed_i(pk),
    .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .left_o(left), .right_o(right), .valid_o(valid)
  );

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected pair actual=%h_%h expected=none", left, right);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({left, right} !== e) begin
          fails++;
          $display("FAIL %s actual=%h_%h expected=%h_%h", t, left, right, e[47:24], e[23:0]);
        end
      end
    end
  end

  function automatic logic [23:0] align(input logic [31:0] w, input int l);
    logic [31:0] s;
    s = w << (24 - l);
    return s[23:0];
  endfunction

  function automatic logic [63:0] place(input logic [31:0] w, input int l, input int s);
    logic [63:0] hb;
    hb = {$urandom, $urandom};
    for (int i = 0; i < l; i++) hb[s+i] = w[l-1-i];
    return hb;
  endfunction

  task automatic drive_bit(input logic w, input logic d, input logic dsp);
    @(negedge clk);
    sck = dsp; ws = w; sd = d;
    repeat (H) @(negedge clk);
    sck = ~dsp;
    repeat (H - 1) @(negedge clk);
  endtask

  task automatic send_half(input logic w, input logic [63:0] hb, input int n);
    for (int i = 0; i < n; i++) drive_bit(w, hb[i], 1'b0);
  endtask

  task automatic expect_pair(input logic [23:0] l, input logic [23:0] r, input string tg);
    exp_q.push_back({l, r});
    tag_q.push_back(tg);
  endtask

  task automatic do_reset(input logic [1:0] f, input logic [1:0] ln, input logic p);
    @(negedge clk);
    rst_n = 1'b0; fmt = f; len = ln; pk = p; sck = 1'b0; ws = 1'b0; sd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic end_check(input string tg);
    repeat (30) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s pending pairs actual=%0d expected=0", tg, exp_q.size());
    end
    exp_q.delete();
    tag_q.delete();
  endtask

  // one frame of a level-framed mode; word of l bits at position s of an n-bit half
  task automatic nd_frame(input logic lvl, input int l, input int s, input int n,
                          input int kept, input string tg);
    logic [31:0] lw, rw;
    lw = $urandom; rw = $urandom;
    if (l < 32) begin lw = lw & ((32'd1 << l) - 1); rw = rw & ((32'd1 << l) - 1); end
    if (kept == 24 && l == 32) expect_pair(lw[31:8], rw[31:8], tg);
    else                       expect_pair(align(lw, l), align(rw, l), tg);
    send_half(lvl, place(lw, l, s), n);
    send_half(~lvl, place(rw, l, s), n);
  endtask

  task automatic nd_run(input logic [1:0] f, input logic [1:0] ln, input logic p,
                        input int l, input int s, input int n, input int frames, input string tg);
    logic lvl;
    lvl = (f == 2'b01) ? 1'b0 : 1'b1;
    do_reset(f, ln, p);
    send_half(~lvl, {$urandom, $urandom}, 5);   // partial half, must be discarded (R11)
    for (int k = 0; k < frames; k++) nd_frame(lvl, l, s, n, 24, tg);
    send_half(lvl, 64'd0, 3);
    end_check("R10");
  endtask

  task automatic dsp_run(input int l, input int frames, input string tg);
    logic [31:0] lw, rw;
    do_reset(2'b11, 2'b00, 1'b0);
    for (int k = 0; k < frames; k++) begin
      lw = $urandom & ((32'd1 << l) - 1);
      rw = $urandom & ((32'd1 << l) - 1);
      expect_pair(align(lw, l), align(rw, l), tg);
      drive_bit(1'b1, 1'($urandom), 1'b1);
      for (int i = 0; i < l; i++) drive_bit(1'b0, lw[l-1-i], 1'b1);
      drive_bit(1'b1, 1'($urandom), 1'b1);
      for (int i = 0; i < l; i++) drive_bit(1'b0, rw[l-1-i], 1'b1);
    end
    drive_bit(1'b1, 1'b0, 1'b1);
    drive_bit(1'b0, 1'b0, 1'b1);
    end_check("R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (left !== 24'd0 || right !== 24'd0 || valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 actual=%h_%h_%b expected=0_0_0", left, right, valid);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (left !== 24'd0 || right !== 24'd0 || valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 after release actual=%h_%h_%b expected=0_0_0", left, right, valid);
    end

    nd_run(2'b10, 2'b00, 1'b0, 24, 0, 32, 3, "R3 left-justified");
    nd_run(2'b10, 2'b00, 1'b0, 32, 0, 32, 2, "R8 truncation");
    nd_run(2'b10, 2'b00, 1'b0, 16, 0, 16, 3, "R9 left-justified 16b packed");
    nd_run(2'b01, 2'b00, 1'b0, 24, 1, 32, 3, "R4 R2 i2s");
    nd_run(2'b00, 2'b00, 1'b0, 24, 8, 32, 2, "R5 rj24");
    nd_run(2'b00, 2'b01, 1'b0, 20, 12, 32, 2, "R5 rj20");
    nd_run(2'b00, 2'b10, 1'b0, 16, 16, 32, 2, "R5 R9 rj16");
    nd_run(2'b00, 2'b00, 1'b0, 24, 8, 40, 2, "R5 rj24 long half");
    nd_run(2'b00, 2'b10, 1'b1, 16, 0, 16, 3, "R7 packed rj");
    dsp_run(24, 3, "R6 dsp 24b");
    dsp_run(18, 2, "R6 R9 dsp 18b");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule